// File: doc/BRIEF.md
# Mid-line receiver arrival equalizer

This block sits at a receiver tapped partway along a line. The line is driven from one end and sent back from the far end, so each transition passes the tap twice. An upstream discriminator turns the two passes into single-cycle pulses. One pulse marks the outgoing (incident) pass and the other marks the return pass. The incident pulse runs through two delay sections connected in series. Both sections always use the same delay code.

Each completed transition steps the shared code by at most one. The step is chosen so that the pulse leaving the second section lines up with the returned pulse. Once the total delay equals the spacing between the two passes, the node between the sections produces the pulse at the moment the far end sees it. That moment is halfway between the two passes. This node drives the equalized output.

Delays are modelled as chains of sample-clock registers. After lock the code is held. A recalibrate request starts a new search from the held code. A receiver placed too close to the line end cannot be equalized, and the block flags it.

Top module: `mid_line_equalizer`

## Requirements
- R1: After reset, code_o is 0 and locked_o, near_end_o and eq_o are all 0.
- R2: Each section delays by D = MIN_DLY + code_o sample cycles. When an incident pulse is sampled at edge E0, eq_o is high for exactly one cycle, and that cycle ends at edge E0+D.
- R3: The second-section output is sampled at edge E0+2D. The return pulse is sampled at edge E0+S. Each transition is judged once both have been seen:
  - If 2D < S (early), the code steps up by one.
  - If 2D > S (late), the code steps down by one.
  - If 2D = S (hit), the code holds.
  - The code saturates at 0 and at 2**CODE_W-1.
- R4: A result counts as settled when it is a hit, or when it is the opposite direction (early versus late) of the previous result. LOCK_RUN settled results in a row assert locked_o. Any other result clears the run.
- R5: While locked_o is 1, code_o is frozen. The output eq_o still follows R2.
- R6: An incident pulse that arrives while a transition is in flight is ignored. A return pulse that arrives while no transition is in flight is also ignored.
- R7: A late result at code 0 sets near_end_o, because the spacing is below 2*MIN_DLY. Any other result clears near_end_o.
- R8: A one-cycle pulse on recal_i clears locked_o, near_end_o, the settled run and the previous-result memory. It keeps code_o.
- R9: code_o changes only on the edge that completes a transition.
- R10: When the block is locked on an even spacing S, eq_o marks edge E0+S/2, which is the far-end arrival time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| inc_i | input | 1 | Incident-pass detection pulse |
| ret_i | input | 1 | Return-pass detection pulse |
| recal_i | input | 1 | Restart the search, clearing lock |
| eq_o | output | 1 | Equalized pulse from the node between the sections |
| code_o | output | CODE_W | Shared section delay code |
| locked_o | output | 1 | Lock reached; code frozen |
| near_end_o | output | 1 | Spacing too short to equalize |

## Verification
The bench builds the block with MIN_DLY=2, CODE_W=3 and LOCK_RUN=3, which gives section delays from 2 to 9 cycles.

With these values the search reaches both code limits within a few transitions:
- a spacing below 4 drives the code down to 0 and raises the near-end flag;
- a spacing above 18 pins the code at 7.

Even spacings lock through repeated hits, and odd spacings lock through alternating early and late results. A short run of three settled results makes lock, freeze and recalibration cheap to repeat under random spacings.

// File: rtl/mle_pkg.sv
package mle_pkg;
  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_HIT   = 2'd1,
    RES_EARLY = 2'd2,
    RES_LATE  = 2'd3
  } mle_res_e;
endpackage

// File: rtl/mle_tap_chain.sv
module mle_tap_chain #(
  parameter int DEPTH = 17,
  localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             d_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             q_o
);
  logic [DEPTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stage_q[0] <= 1'b0;
    else if (flush_i) stage_q[0] <= 1'b0;
    else              stage_q[0] <= d_i;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[i] <= 1'b0;
      else if (flush_i) stage_q[i] <= 1'b0;
      else              stage_q[i] <= stage_q[i-1];
    end
  end

  // stage k holds the input delayed by k+1 cycles
  assign q_o = (int'(sel_i) < DEPTH) ? stage_q[sel_i] : 1'b0;
endmodule

// File: rtl/mle_phase_det.sv
module mle_phase_det
  import mle_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     inc_i,
  input  logic     end_i,
  input  logic     ret_i,
  output logic     start_o,
  output logic     busy_o,
  output logic     done_o,
  output mle_res_e res_o
);
  logic busy_q, end_seen_q, ret_seen_q;
  logic end_any, ret_any;

  assign start_o = inc_i & ~busy_q;
  assign end_any = end_seen_q | end_i;
  assign ret_any = ret_seen_q | ret_i;
  assign done_o  = busy_q & end_any & ret_any;
  assign busy_o  = busy_q;

  always_comb begin
    if (end_seen_q)      res_o = RES_EARLY;
    else if (ret_seen_q) res_o = RES_LATE;
    else                 res_o = RES_HIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      end_seen_q <= 1'b0;
      ret_seen_q <= 1'b0;
    end else if (done_o) begin
      busy_q     <= 1'b0;
      end_seen_q <= 1'b0;
      ret_seen_q <= 1'b0;
    end else if (start_o) begin
      busy_q     <= 1'b1;
      end_seen_q <= 1'b0;
      ret_seen_q <= 1'b0;
    end else if (busy_q) begin
      end_seen_q <= end_any;
      ret_seen_q <= ret_any;
    end
  end
endmodule

// File: rtl/mle_code_ctrl.sv
module mle_code_ctrl
  import mle_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int LOCK_RUN = 4,
  localparam int RUN_W   = $clog2(LOCK_RUN + 1),
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              recal_i,
  input  logic              done_i,
  input  mle_res_e          res_i,
  output logic [CODE_W-1:0] code_o,
  output logic              locked_o,
  output logic              near_end_o
);
  logic [CODE_W-1:0] code_q;
  logic [RUN_W-1:0]  run_q;
  mle_res_e          prev_q;
  logic              locked_q, near_q, settled;

  assign settled = (res_i == RES_HIT)
                 || (res_i == RES_EARLY && prev_q == RES_LATE)
                 || (res_i == RES_LATE  && prev_q == RES_EARLY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= '0;
      run_q    <= '0;
      prev_q   <= RES_NONE;
      locked_q <= 1'b0;
      near_q   <= 1'b0;
    end else if (recal_i) begin
      run_q    <= '0;
      prev_q   <= RES_NONE;
      locked_q <= 1'b0;
      near_q   <= 1'b0;
    end else if (done_i) begin
      near_q <= (res_i == RES_LATE) && (code_q == '0);
      prev_q <= res_i;
      if (!locked_q) begin
        if (res_i == RES_EARLY && code_q != CODE_MAX) code_q <= code_q + 1'b1;
        if (res_i == RES_LATE  && code_q != '0)       code_q <= code_q - 1'b1;
        if (settled) begin
          run_q <= run_q + 1'b1;
          if (int'(run_q) == LOCK_RUN - 1) locked_q <= 1'b1;
        end else begin
          run_q <= '0;
        end
      end
    end
  end

  assign code_o     = code_q;
  assign locked_o   = locked_q;
  assign near_end_o = near_q;
endmodule

// File: rtl/mid_line_equalizer.sv
module mid_line_equalizer
  import mle_pkg::*;
#(
  parameter int MIN_DLY  = 2,
  parameter int CODE_W   = 4,
  parameter int LOCK_RUN = 4,
  localparam int DEPTH   = MIN_DLY + (1 << CODE_W) - 1,
  localparam int TAP_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              ret_i,
  input  logic              recal_i,
  output logic              eq_o,
  output logic [CODE_W-1:0] code_o,
  output logic              locked_o,
  output logic              near_end_o
);
  logic       start, busy, done, mid_pulse, end_pulse;
  mle_res_e   res;
  logic [TAP_W-1:0] tap;

  assign tap = TAP_W'(MIN_DLY - 1) + TAP_W'(code_o);

  mle_tap_chain #(.DEPTH(DEPTH)) i_sec_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(done),
    .d_i(start), .sel_i(tap), .q_o(mid_pulse)
  );

  mle_tap_chain #(.DEPTH(DEPTH)) i_sec_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(done),
    .d_i(mid_pulse), .sel_i(tap), .q_o(end_pulse)
  );

  mle_phase_det i_pd (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc_i), .end_i(end_pulse),
    .ret_i(ret_i), .start_o(start), .busy_o(busy), .done_o(done), .res_o(res)
  );

  mle_code_ctrl #(.CODE_W(CODE_W), .LOCK_RUN(LOCK_RUN)) i_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .recal_i(recal_i), .done_i(done),
    .res_i(res), .code_o(code_o), .locked_o(locked_o), .near_end_o(near_end_o)
  );

  assign eq_o = mid_pulse;
endmodule

// File: rtl/mid_line_equalizer_chk.sv
module mid_line_equalizer_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              recal_i,
  input logic              eq_o,
  input logic [CODE_W-1:0] code_o,
  input logic              locked_o,
  input logic              near_end_o,
  input logic              busy,
  input logic              done
);
  AST_CODE_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(code_o)); // R9
  AST_FROZEN_WHEN_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !recal_i) |=> ($stable(code_o) && locked_o)); // R5
  AST_RECAL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recal_i |=> (!locked_o && !near_end_o)); // R8
  AST_EQ_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eq_o |-> busy); // R6
  AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !busy); // R3
endmodule

bind mid_line_equalizer mid_line_equalizer_chk #(.CODE_W(CODE_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .recal_i(recal_i), .eq_o(eq_o),
  .code_o(code_o), .locked_o(locked_o), .near_end_o(near_end_o),
  .busy(busy), .done(done)
);

// File: tb/test_mid_line_equalizer.sv
module test_mid_line_equalizer;
  localparam int MIN_DLY  = 2;
  localparam int CODE_W   = 3;
  localparam int LOCK_RUN = 3;
  localparam int CMAX     = (1 << CODE_W) - 1;

  logic clk = 1'b0, rst_ni = 1'b0, inc_i = 1'b0, ret_i = 1'b0, recal_i = 1'b0;
  logic eq_o, locked_o, near_end_o;
  logic [CODE_W-1:0] code_o;

  int n_chk = 0, n_bad = 0;
  int m_code = 0, m_prev = 0, m_run = 0; // prev: 0 none 1 hit 2 early 3 late
  bit m_lock = 0, m_near = 0;

  always #4 clk = ~clk;

  mid_line_equalizer #(.MIN_DLY(MIN_DLY), .CODE_W(CODE_W), .LOCK_RUN(LOCK_RUN))
    i_mid_line_equalizer (.clk_i(clk), .rst_ni(rst_ni), .inc_i(inc_i), .ret_i(ret_i),
      .recal_i(recal_i), .eq_o(eq_o), .code_o(code_o), .locked_o(locked_o),
      .near_end_o(near_end_o));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int judge(input int s, input int d);
    if (2 * d < s) return 2;
    if (2 * d > s) return 3;
    return 1;
  endfunction

  task automatic model_step(input int r);
    bit settled;
    settled = (r == 1) || (r == 2 && m_prev == 3) || (r == 3 && m_prev == 2);
    m_near = (r == 3) && (m_code == 0);
    m_prev = r;
    if (!m_lock) begin
      if (r == 2 && m_code < CMAX) m_code++;
      if (r == 3 && m_code > 0) m_code--;
      if (settled) begin
        m_run++;
        if (m_run == LOCK_RUN) m_lock = 1;
      end else m_run = 0;
    end
  endtask

  task automatic check_state(input string tag);
    check(int'(code_o) == m_code, {tag, " code"}, int'(code_o), m_code);
    check(locked_o == m_lock, {tag, " locked"}, locked_o, m_lock);
    check(near_end_o == m_near, {tag, " near_end"}, near_end_o, m_near);
  endtask

  // called at a negedge with the block idle
  task automatic run_tr(input int s, input int extra_k, input string tag);
    int d, kmax, hits, pos, r;
    d = MIN_DLY + m_code;
    kmax = ((s > 2 * d) ? s : 2 * d) + 3;
    hits = 0; pos = -1;
    inc_i = 1'b1;
    @(negedge clk);
    inc_i = 1'b0;
    for (int k = 1; k <= kmax; k++) begin
      ret_i = (k == s);
      inc_i = (k == extra_k);
      if (eq_o) begin hits++; pos = k; end
      @(negedge clk);
    end
    ret_i = 1'b0; inc_i = 1'b0;
    check(hits == 1, {tag, " R2 eq pulse count"}, hits, 1);
    check(pos == d, {tag, " R2 eq position"}, pos, d);
    r = judge(s, d);
    model_step(r);
    check_state({tag, " R3"});
  endtask

  task automatic recal();
    recal_i = 1'b1;
    @(negedge clk);
    recal_i = 1'b0;
    m_lock = 0; m_near = 0; m_run = 0; m_prev = 0;
    @(negedge clk);
    check_state("R8 recal");
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int s, p;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check(eq_o == 1'b0, "R1 eq", eq_o, 0);
    check_state("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check_state("R1 after release");

    // even spacing: climb then lock by hits
    for (int i = 0; i < 8; i++) run_tr(10, 0, "R4 even");
    check(m_lock == 1'b1, "R4 lock reached", m_lock, 1);
    check(int'(code_o) == 3, "R10 locked code", int'(code_o), 3);
    run_tr(10, 0, "R10 midpoint");
    // frozen while locked
    run_tr(16, 0, "R5 frozen");
    run_tr(4, 0, "R5 frozen late");
    // extra incident pulse in flight is ignored
    run_tr(10, 2, "R6 extra inc");
    // return pulse while idle is ignored
    ret_i = 1'b1; @(negedge clk); ret_i = 1'b0;
    repeat (3) @(negedge clk);
    check_state("R6 idle ret");

    recal();
    for (int i = 0; i < 8; i++) run_tr(13, 0, "R4 odd");
    check(m_lock == 1'b1, "R4 odd lock", m_lock, 1);

    recal();
    for (int i = 0; i < 8; i++) run_tr(3, 0, "R7 near");
    check(near_end_o == 1'b1, "R7 flag", near_end_o, 1);
    run_tr(6, 0, "R7 clear");

    recal();
    for (int i = 0; i < 10; i++) run_tr(40, 0, "R3 sat high");
    check(int'(code_o) == CMAX, "R3 max", int'(code_o), CMAX);

    for (int i = 0; i < 50; i++) begin
      p = int'($urandom_range(0, 9));
      s = int'($urandom_range(1, 2 * (MIN_DLY + CMAX) + 4));
      if (p == 0) recal();
      else if (p == 1) run_tr(s, 2, "R6 rand");
      else run_tr(s, 0, "R3 rand");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule